// File: doc/BRIEF.md
# Display Adapter PCI Configuration Header

This block is the type-0 configuration space target of a display adapter. The host reaches it one dword at a time. The dword is selected by a six-bit index, and a four-bit byte-enable mask qualifies each write. Reads are combinational from the selected index. The header holds the identification, class and revision, a command register with I/O and memory enables, and the interrupt dword. It also holds three base address registers with fixed types and power-of-two windows: a memory aperture, an I/O window and a small memory window. Software sizes each window by writing all ones and reading back the mask.

From the stored base addresses and the command enables, the block decodes two address streams. An incoming I/O address produces an I/O hit and an offset relative to the I/O window base. An incoming memory address produces a hit on the aperture. Bus protocol phases, parity, capability lists and bus mastering are handled elsewhere.

Top module: `disp_cfg_header`

## Requirements
- R1: Dword index 0 (offset 0x00) reads {DEVICE_ID, VENDOR_ID}, with the device ID in bits 31:16, and writes to it have no effect.
- R2: Dword index 2 (offset 0x08) reads 0x0300005C: class code 0x030000 in bits 31:8 and revision 0x5C in bits 7:0.
- R3: Dword index 15 (offset 0x3C) resets to 0x00080100. Only bits 7:0 (the interrupt line) are writable. Bits 15:8 always read 0x01 and bits 23:16 always read 0x08.
- R4: Dword index 1 (offset 0x04) holds the I/O enable in bit 0 and the memory enable in bit 1. Both reset to 0 and are writable through byte enable 0. All other bits of this dword read 0.
- R5: Writing 0xFFFFFFFF with all byte enables to index 4 (0x10), 5 (0x14) or 6 (0x18) makes that index read back 0xFF000000, 0xFFFFFF01 or 0xFFFFF000 respectively.
- R6: In each BAR, only the address bits at or above the window size (bit 24, bit 8 and bit 12 for the three BARs) are writable. Bit 0 of index 5 always reads 1 and every other low bit reads 0. After reset the three BARs read 0x00000000, 0x00000001 and 0x00000000.
- R7: During a write, byte enable bit i alone decides whether byte i (bits 8i+7:8i) of a writable register is updated. A byte whose enable is 0 keeps its value.
- R8: Every index other than 0, 1, 2, 4, 5, 6 and 15 reads 0 whatever was written. This covers the three unused BARs (0x1C, 0x20, 0x24) and the expansion ROM base (0x30).
- R9: io_hit is 1 exactly when the I/O enable is set and io_addr[31:8] equals BAR1[31:8]. While io_hit is 1, io_offset equals io_addr minus the BAR1 base (BAR1 with bits 1:0 cleared). io_offset is 0 when io_hit is 0.
- R10: mem_hit is 1 exactly when the memory enable is set and mem_addr[31:24] equals BAR0[31:24].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_dw_idx | input | 6 | Dword index of the configuration access |
| cfg_wr | input | 1 | Write strobe, one cycle per write |
| cfg_be | input | 4 | Byte enables of the write |
| cfg_wdata | input | 32 | Write data |
| cfg_rdata | output | 32 | Read data of the indexed dword |
| io_addr | input | 32 | I/O address to decode |
| io_hit | output | 1 | I/O address falls in the enabled I/O window |
| io_offset | output | 8 | Offset of io_addr inside the I/O window |
| mem_addr | input | 32 | Memory address to decode |
| mem_hit | output | 1 | Memory address falls in the enabled aperture |

## Verification
On every cycle, the assertions check the following. The all-ones sizing readback of each BAR. That disabled byte lanes hold their value. That both hit outputs are gated by their command enables. That io_offset equals the arithmetic difference from the window base. That the read-only interrupt bytes and the zero-reading BAR slots keep their values.

Only the bench scenarios can show the rest. The full byte-enable sweep against each BAR mask needs them, and so do the exact window edges of both decoders, the constant identification dwords and the reset values.

// File: rtl/disp_cfg_pkg.sv
package disp_cfg_pkg;

    localparam int NUM_BARS = 3;

    localparam logic [5:0] IDX_ID    = 6'd0;
    localparam logic [5:0] IDX_CMD   = 6'd1;
    localparam logic [5:0] IDX_CLASS = 6'd2;
    localparam logic [5:0] IDX_BAR0  = 6'd4;
    localparam logic [5:0] IDX_INTR  = 6'd15;

    typedef struct packed {
        logic                          io_en;
        logic                          mem_en;
        logic [NUM_BARS-1:0][31:0]     bar;
        logic [7:0]                    int_line;
    } cfg_state_t;

    // Update only enabled bytes, and inside them only the writable bits.
    function automatic logic [31:0] lane_merge(input logic [31:0] old_v,
                                               input logic [31:0] new_v,
                                               input logic [3:0]  be,
                                               input logic [31:0] wmask);
        logic [31:0] res;
        res = old_v;
        for (int i = 0; i < 4; i++) begin
            if (be[i]) begin
                res[8*i +: 8] = (old_v[8*i +: 8] & ~wmask[8*i +: 8]) |
                                (new_v[8*i +: 8] &  wmask[8*i +: 8]);
            end
        end
        return res;
    endfunction

endpackage

// File: rtl/disp_cfg_bar.sv
module disp_cfg_bar
    import disp_cfg_pkg::*;
#(
    parameter int SIZE_LOG2 = 24,
    parameter bit IS_IO     = 1'b0
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_sel,
    input  logic [3:0]  be,
    input  logic [31:0] wdata,
    input  logic [31:0] bar_q,
    output logic [31:0] bar_d,
    output logic [31:0] rd_value
);
    localparam logic [31:0] WMASK    = {32{1'b1}} << SIZE_LOG2;
    localparam logic [31:0] TYPE_BIT = {31'd0, IS_IO};

    always_comb begin
        bar_d    = wr_sel ? lane_merge(bar_q, wdata, be, WMASK) : bar_q;
        rd_value = (bar_q & WMASK) | TYPE_BIT;
    end

    // R5: all-ones sizing write reads back mask plus type
    a_r5_sizing_readback: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_sel && be == 4'hF && wdata == 32'hFFFF_FFFF) |=> rd_value == (WMASK | TYPE_BIT));

    // R7: a lane with its enable clear keeps its value
    a_r7_lane_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_sel && !be[3]) |=> rd_value[31:24] == $past(rd_value[31:24]));

    // R6: type and low bits fixed
    a_r6_low_bits: assert property (@(posedge clk) disable iff (!rst_n)
        rd_value[SIZE_LOG2-1:0] == TYPE_BIT[SIZE_LOG2-1:0]);

endmodule

// File: rtl/disp_cfg_decode.sv
module disp_cfg_decode #(
    parameter int WIN_LOG2 = 8
) (
    input  logic        enable,
    input  logic [31:0] base,
    input  logic [31:0] addr,
    output logic        hit
);
    always_comb begin
        hit = enable && ((addr >> WIN_LOG2) == (base >> WIN_LOG2));
    end
endmodule

// File: rtl/disp_cfg_header.sv
module disp_cfg_header
    import disp_cfg_pkg::*;
#(
    parameter logic [15:0] VENDOR_ID      = 16'h1002,
    parameter logic [15:0] DEVICE_ID      = 16'h4750,
    parameter logic [23:0] CLASS_CODE     = 24'h030000,
    parameter logic [7:0]  REVISION       = 8'h5C,
    parameter logic [7:0]  INT_PIN        = 8'h01,
    parameter logic [7:0]  MIN_GNT        = 8'h08,
    parameter logic [7:0]  MAX_LAT        = 8'h00,
    parameter int          APER_LOG2      = 24,
    parameter int          IO_LOG2        = 8,
    parameter int          AUX_LOG2       = 12
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [5:0]         cfg_dw_idx,
    input  logic               cfg_wr,
    input  logic [3:0]         cfg_be,
    input  logic [31:0]        cfg_wdata,
    output logic [31:0]        cfg_rdata,
    input  logic [31:0]        io_addr,
    output logic               io_hit,
    output logic [IO_LOG2-1:0] io_offset,
    input  logic [31:0]        mem_addr,
    output logic               mem_hit
);
    localparam int BAR_LOG2 [NUM_BARS] = '{APER_LOG2, IO_LOG2, AUX_LOG2};

    cfg_state_t state_q, state_d;

    logic [NUM_BARS-1:0][31:0] bar_next;
    logic [NUM_BARS-1:0][31:0] bar_rd;
    logic                      io_win;
    logic [31:0]               io_base;

    for (genvar g = 0; g < NUM_BARS; g++) begin : g_bar
        disp_cfg_bar #(
            .SIZE_LOG2 (BAR_LOG2[g]),
            .IS_IO     (g == 1)
        ) u_bar (
            .clk      (clk),
            .rst_n    (rst_n),
            .wr_sel   (cfg_wr && cfg_dw_idx == IDX_BAR0 + 6'(g)),
            .be       (cfg_be),
            .wdata    (cfg_wdata),
            .bar_q    (state_q.bar[g]),
            .bar_d    (bar_next[g]),
            .rd_value (bar_rd[g])
        );
    end

    assign io_base = {bar_rd[1][31:2], 2'b00};

    disp_cfg_decode #(.WIN_LOG2(IO_LOG2)) u_io_dec (
        .enable (state_q.io_en),
        .base   (io_base),
        .addr   (io_addr),
        .hit    (io_win)
    );

    disp_cfg_decode #(.WIN_LOG2(APER_LOG2)) u_mem_dec (
        .enable (state_q.mem_en),
        .base   (bar_rd[0]),
        .addr   (mem_addr),
        .hit    (mem_hit)
    );

    always_comb begin
        io_hit    = io_win;
        io_offset = io_win ? io_addr[IO_LOG2-1:0] : '0;
    end

    // Next-state process
    always_comb begin
        state_d     = state_q;
        state_d.bar = bar_next;
        if (cfg_wr && cfg_be[0]) begin
            if (cfg_dw_idx == IDX_CMD) begin
                state_d.io_en  = cfg_wdata[0];
                state_d.mem_en = cfg_wdata[1];
            end
            if (cfg_dw_idx == IDX_INTR) begin
                state_d.int_line = cfg_wdata[7:0];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    // Read mux
    always_comb begin
        cfg_rdata = '0;
        unique case (cfg_dw_idx)
            IDX_ID:         cfg_rdata = {DEVICE_ID, VENDOR_ID};
            IDX_CMD:        cfg_rdata = {30'd0, state_q.mem_en, state_q.io_en};
            IDX_CLASS:      cfg_rdata = {CLASS_CODE, REVISION};
            IDX_BAR0:       cfg_rdata = bar_rd[0];
            IDX_BAR0 + 6'd1: cfg_rdata = bar_rd[1];
            IDX_BAR0 + 6'd2: cfg_rdata = bar_rd[2];
            IDX_INTR:       cfg_rdata = {MAX_LAT, MIN_GNT, INT_PIN, state_q.int_line};
            default:        cfg_rdata = '0;
        endcase
    end

    // R9: I/O hit only with the I/O enable set
    a_r9_io_gate: assert property (@(posedge clk) disable iff (!rst_n)
        io_hit |-> state_q.io_en);

    // R9: offset is the arithmetic distance from the window base
    a_r9_io_offset: assert property (@(posedge clk) disable iff (!rst_n)
        io_hit |-> (io_offset == IO_LOG2'(io_addr - io_base)) && (io_addr >= io_base));

    // R10: aperture hit only with the memory enable set
    a_r10_mem_gate: assert property (@(posedge clk) disable iff (!rst_n)
        mem_hit |-> state_q.mem_en);

    // R8: unused BAR slots and expansion ROM read zero
    a_r8_unused_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_dw_idx == 6'd7 || cfg_dw_idx == 6'd8 || cfg_dw_idx == 6'd9 || cfg_dw_idx == 6'd12)
        |-> cfg_rdata == 32'd0);

    // R3: read-only interrupt bytes keep their values
    a_r3_intr_fixed: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_dw_idx == IDX_INTR |-> cfg_rdata[31:8] == {MAX_LAT, MIN_GNT, INT_PIN});

endmodule

// File: tb/disp_cfg_header_bench.sv
module disp_cfg_header_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [5:0]  cfg_dw_idx = '0;
    logic        cfg_wr = 1'b0;
    logic [3:0]  cfg_be = '0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic [31:0] io_addr = '0;
    logic        io_hit;
    logic [7:0]  io_offset;
    logic [31:0] mem_addr = '0;
    logic        mem_hit;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    disp_cfg_header u_disp_cfg_header (
        .clk(clk), .rst_n(rst_n), .cfg_dw_idx(cfg_dw_idx), .cfg_wr(cfg_wr),
        .cfg_be(cfg_be), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
        .io_addr(io_addr), .io_hit(io_hit), .io_offset(io_offset),
        .mem_addr(mem_addr), .mem_hit(mem_hit)
    );

    function automatic logic [31:0] exp_merge(input logic [31:0] o, input logic [31:0] n,
                                              input logic [3:0] be, input logic [31:0] m);
        logic [31:0] bm;
        bm = {{8{be[3]}}, {8{be[2]}}, {8{be[1]}}, {8{be[0]}}} & m;
        return (o & ~bm) | (n & bm);
    endfunction

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic wr(input logic [5:0] idx, input logic [31:0] d, input logic [3:0] be);
        @(negedge clk);
        cfg_dw_idx = idx; cfg_wdata = d; cfg_be = be; cfg_wr = 1'b1;
        @(negedge clk);
        cfg_wr = 1'b0;
    endtask

    task automatic rd(input logic [5:0] idx, input logic [31:0] exp, input string req);
        cfg_dw_idx = idx;
        #1;
        check(req, cfg_rdata, exp);
    endtask

    localparam logic [31:0] MASKS [3] = '{32'hFF00_0000, 32'hFFFF_FF00, 32'hFFFF_F000};
    localparam logic [31:0] TYPES [3] = '{32'h0, 32'h1, 32'h0};

    initial begin
        #(8 * 200000);
        if (!finished) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [31:0] base;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // reset state
        rd(6'd0,  32'h4750_1002, "R1 id");
        rd(6'd2,  32'h0300_005C, "R2 class");
        rd(6'd15, 32'h0008_0100, "R3 intr reset");
        rd(6'd1,  32'h0,         "R4 cmd reset");
        rd(6'd4,  32'h0,         "R6 bar0 reset");
        rd(6'd5,  32'h1,         "R6 bar1 reset");
        rd(6'd6,  32'h0,         "R6 bar2 reset");
        check("R9 io_hit reset", {31'd0, io_hit}, 32'd0);

        // R1 write ignored
        wr(6'd0, 32'h0, 4'hF);
        rd(6'd0, 32'h4750_1002, "R1 id after write");

        // R3 interrupt dword
        wr(6'd15, 32'hFFFF_FFFF, 4'hF);
        rd(6'd15, 32'h0008_01FF, "R3 intr line write");
        wr(6'd15, 32'h0000_0033, 4'hE);
        rd(6'd15, 32'h0008_01FF, "R3 intr be masked");

        // R4 command
        wr(6'd1, 32'hFFFF_FFFF, 4'hF);
        rd(6'd1, 32'h3, "R4 cmd all ones");
        wr(6'd1, 32'h0, 4'hE);
        rd(6'd1, 32'h3, "R4 cmd lane0 disabled");
        wr(6'd1, 32'h0, 4'h1);
        rd(6'd1, 32'h0, "R4 cmd clear");

        // R5 sizing
        for (int b = 0; b < 3; b++) begin
            wr(6'(4 + b), 32'hFFFF_FFFF, 4'hF);
            rd(6'(4 + b), MASKS[b] | TYPES[b], "R5 sizing readback");
        end

        // R6/R7 byte-enable sweep on every BAR
        for (int be = 0; be < 16; be++) begin
            for (int b = 0; b < 3; b++) begin
                logic [31:0] pat;
                pat = 32'hC3A5_9E7F ^ {8{be[3:0]}};
                wr(6'(4 + b), 32'h0, 4'hF);
                wr(6'(4 + b), pat, 4'(be));
                rd(6'(4 + b), exp_merge(32'h0, pat, 4'(be), MASKS[b]) | TYPES[b],
                   "R7 R6 byte enable merge");
            end
        end

        // R8 unused offsets
        for (int i = 0; i < 64; i++) begin
            if (!(i inside {0, 1, 2, 4, 5, 6, 15})) begin
                wr(6'(i), 32'hFFFF_FFFF, 4'hF);
                rd(6'(i), 32'h0, "R8 unused reads zero");
            end
        end

        // R9 I/O decode sweep, disabled then enabled
        base = 32'h0000_1200;
        wr(6'd5, base | 32'h0000_00FE, 4'hF);
        rd(6'd5, base | 32'h1, "R6 bar1 low bits fixed");
        for (int en = 0; en < 2; en++) begin
            wr(6'd1, {31'd0, en[0]}, 4'h1);
            for (int a = 32'h10F0; a < 32'h1410; a += 3) begin
                logic exp_hit;
                io_addr = a;
                #1;
                exp_hit = en[0] && (a >= base) && (a < base + 256);
                check("R9 io_hit", {31'd0, io_hit}, {31'd0, exp_hit});
                check("R9 io_offset", {24'd0, io_offset},
                      exp_hit ? 32'(8'(a - base)) : 32'd0);
            end
        end

        // R10 aperture decode
        wr(6'd4, 32'h5A12_3456, 4'hF);
        rd(6'd4, 32'h5A00_0000, "R6 bar0 stored base");
        for (int en = 0; en < 2; en++) begin
            wr(6'd1, {30'd0, en[0], 1'b0}, 4'h1);
            for (int k = 0; k < 4; k++) begin
                logic [31:0] aa;
                logic        eh;
                aa = (k == 0) ? 32'h59FF_FFFF : (k == 1) ? 32'h5A00_0000 :
                     (k == 2) ? 32'h5AFF_FFFF : 32'h5B00_0000;
                mem_addr = aa;
                #1;
                eh = en[0] && (aa[31:24] == 8'h5A);
                check("R10 mem_hit", {31'd0, mem_hit}, {31'd0, eh});
            end
        end

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule